// File: doc/BRIEF.md
# Serial NOR flash program and erase sequencer

This block sits on the host side of a single-line SPI link to a serial NOR flash. It carries out the write-type operations of the flash: page program, 4 KB sector erase, 64 KB block erase, chip erase and status-register write. The user posts one operation on a request port. The request carries an operation code, a 24-bit address and a byte count. The sequencer then runs three chip-select frames in turn. The first frame sets the write-enable latch of the flash. The second frame sends the operation opcode, followed by the address and any payload that the operation takes. The third frame issues the read-status command and keeps clocking in status bytes until the busy bit clears.

Page data and the status-register value come in on a byte stream with valid/ready handshaking. When no byte is waiting, the serial clock is held low at the byte boundary. A rejected command is one the flash never started, for example because the target region is protected. The sequencer detects this when the first status byte shows both the busy bit and the write-enable latch clear, and it reports a protection error. A poll limit guards against a busy bit that never clears. Completion is a single-cycle pulse that carries both error flags.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset, cs_n is high, sclk is low, done is low and req_ready is high. req_ready is high only while the sequencer is idle, and cs_n is high at that time.
- R2: Every accepted request first sends a frame made of the single byte 06h.
- R3: The second frame depends on req_op. Code 0 (page program) sends 02h, three address bytes, then req_len_m1+1 data bytes. Code 1 (sector erase) sends 20h and three address bytes. Code 2 (block erase) sends D8h and three address bytes. Code 3 (chip erase) sends C7h alone. Code 4 (status write) sends 01h and one data byte.
- R4: Bytes go out MSB first on mosi. mosi changes only while sclk is low, and the flash samples it on the rising edge of sclk. The three address bytes are sent as req_addr[23:16], then [15:8], then [7:0]. miso is sampled on the rising edge of sclk.
- R5: sclk is low whenever cs_n is high. cs_n rises only after a whole number of bytes, that is, after a multiple of 8 rising sclk edges in the frame.
- R6: Between frames, cs_n stays high for at least CS_GAP system clock cycles.
- R7: Each high phase of sclk lasts exactly SCLK_DIV system clock cycles. Each low phase lasts at least SCLK_DIV cycles.
- R8: wr_ready is high only inside a frame, with sclk low. A byte is taken when wr_valid and wr_ready are both high in the same cycle. While no byte is offered, sclk stays low at the byte boundary.
- R9: The third frame sends 05h and then reads status bytes until one of them has bit 0 (busy) at 0. It then ends with done high and both error flags low.
- R10: If the first status byte has bit 0 and bit 1 (write-enable latch) both at 0, the frame ends and done pulses with err_prot high.
- R11: If TMO_POLLS status bytes in a row show bit 0 at 1, the frame ends and done pulses with err_timeout high.
- R12: done is a single-cycle pulse, and err_prot and err_timeout are high only together with it. After done, req_ready returns once the CS_GAP interval has passed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Operation request |
| req_ready | output | 1 | Request accepted this cycle when high together with req_valid |
| req_op | input | 3 | Operation: 0 program, 1 sector erase, 2 block erase, 3 chip erase, 4 status write; 5 to 7 reserved |
| req_addr | input | 24 | Target byte address |
| req_len_m1 | input | 8 | Page program byte count minus one |
| wr_valid | input | 1 | Payload byte available |
| wr_data | input | 8 | Payload byte |
| wr_ready | output | 1 | Payload byte taken this cycle |
| done | output | 1 | Operation finished (one-cycle pulse) |
| err_prot | output | 1 | Command rejected by the flash, valid with done |
| err_timeout | output | 1 | Busy poll limit reached, valid with done |
| sclk | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |

## Verification
The write-enable frame starts one cycle after the request is accepted. Each serial bit then takes 2*SCLK_DIV cycles, and cs_n rises one cycle after the final falling sclk edge of a frame. done arrives one cycle after the falling edge that completes the deciding status byte. Because of this timing, the bench never predicts an absolute cycle. It follows the handshakes and the done pulse, samples every output on the falling system-clock edge, and compares the captured frames byte by byte with the sequences that the requirements derive from the request. The one fixed-time check is the stall check: 60 cycles after a byte is accepted with no further data offered, the bit count on the bus must sit exactly at that byte's boundary.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    localparam logic [2:0] OP_PAGE  = 3'd0;
    localparam logic [2:0] OP_SECT  = 3'd1;
    localparam logic [2:0] OP_BLOCK = 3'd2;
    localparam logic [2:0] OP_CHIP  = 3'd3;
    localparam logic [2:0] OP_WRSR  = 3'd4;

    localparam logic [7:0] CMD_WEN  = 8'h06;
    localparam logic [7:0] CMD_RDSR = 8'h05;

    typedef enum logic [2:0] {
        ST_IDLE, ST_WEN, ST_GAP, ST_CMD, ST_ADDR, ST_DATA, ST_POLL
    } seq_st_e;

    typedef struct packed {
        logic [2:0]  op;
        logic [23:0] addr;
        logic [7:0]  len_m1;
    } seq_req_t;

    function automatic logic [7:0] op_code(input logic [2:0] op);
        case (op)
            OP_PAGE:  op_code = 8'h02;
            OP_SECT:  op_code = 8'h20;
            OP_BLOCK: op_code = 8'hD8;
            OP_WRSR:  op_code = 8'h01;
            default:  op_code = 8'hC7;
        endcase
    endfunction

    function automatic logic [7:0] addr_byte(input logic [23:0] a, input logic [7:0] idx);
        case (idx)
            8'd0:    addr_byte = a[23:16];
            8'd1:    addr_byte = a[15:8];
            default: addr_byte = a[7:0];
        endcase
    endfunction

endpackage

// File: rtl/flash_spi_shift.sv
module flash_spi_shift #(
    parameter int SCLK_DIV = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx
);
    localparam int CW = $clog2(SCLK_DIV + 1);

    logic [CW-1:0] cnt;
    logic [2:0]    bitn;
    logic [7:0]    sh;
    logic          act;

    assign mosi = sh[7];

    always_ff @(posedge clk) begin
        if (rst) begin
            act  <= 1'b0;
            cnt  <= '0;
            bitn <= '0;
            sh   <= '0;
            rx   <= '0;
            sclk <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!act) begin
                if (start) begin
                    act  <= 1'b1;
                    sh   <= tx;
                    cnt  <= '0;
                    bitn <= '0;
                end
            end else if (cnt == CW'(SCLK_DIV - 1)) begin
                cnt <= '0;
                if (!sclk) begin
                    sclk <= 1'b1;
                    rx   <= {rx[6:0], miso};
                end else begin
                    sclk <= 1'b0;
                    if (bitn == 3'd7) begin
                        act  <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        bitn <= bitn + 3'd1;
                        sh   <= {sh[6:0], 1'b0};
                    end
                end
            end else begin
                cnt <= cnt + CW'(1);
            end
        end
    end
endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
    import flash_seq_pkg::*;
#(
    parameter int CS_GAP    = 3,
    parameter int TMO_POLLS = 1000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  seq_req_t   req,
    output logic       req_ready,
    input  logic       wr_valid,
    input  logic [7:0] wr_data,
    output logic       wr_ready,
    output logic       done,
    output logic       err_prot,
    output logic       err_timeout,
    output logic       cs_n,
    output logic       sh_start,
    output logic [7:0] sh_tx,
    input  logic       sh_done,
    input  logic [7:0] sh_rx
);
    localparam int GW = $clog2(CS_GAP + 1);
    localparam int TW = $clog2(TMO_POLLS + 1);

    seq_st_e       st, ret;
    seq_req_t      cur;
    logic [7:0]    bcnt;
    logic          pend;
    logic [GW-1:0] gcnt;
    logic [TW-1:0] pcnt;
    logic          in_byte;
    logic [7:0]    last_data;

    assign in_byte   = (st == ST_WEN) || (st == ST_CMD) || (st == ST_ADDR) ||
                       (st == ST_DATA) || (st == ST_POLL);
    assign sh_start  = in_byte && !pend && ((st != ST_DATA) || wr_valid);
    assign wr_ready  = (st == ST_DATA) && !pend && wr_valid;
    assign req_ready = (st == ST_IDLE);
    assign last_data = (cur.op == OP_PAGE) ? cur.len_m1 : 8'd0;

    always_comb begin
        case (st)
            ST_WEN:  sh_tx = CMD_WEN;
            ST_CMD:  sh_tx = op_code(cur.op);
            ST_ADDR: sh_tx = addr_byte(cur.addr, bcnt);
            ST_DATA: sh_tx = wr_data;
            ST_POLL: sh_tx = (bcnt == 8'd0) ? CMD_RDSR : 8'h00;
            default: sh_tx = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_IDLE;
            ret         <= ST_IDLE;
            cur         <= '0;
            bcnt        <= '0;
            pend        <= 1'b0;
            gcnt        <= '0;
            pcnt        <= '0;
            cs_n        <= 1'b1;
            done        <= 1'b0;
            err_prot    <= 1'b0;
            err_timeout <= 1'b0;
        end else begin
            done        <= 1'b0;
            err_prot    <= 1'b0;
            err_timeout <= 1'b0;
            if (sh_start) pend <= 1'b1;
            case (st)
                ST_IDLE: if (req_valid) begin
                    cur  <= req;
                    st   <= ST_WEN;
                    cs_n <= 1'b0;
                    bcnt <= '0;
                    pcnt <= '0;
                end
                ST_GAP: if (gcnt == GW'(CS_GAP - 1)) begin
                    gcnt <= '0;
                    st   <= ret;
                    if (ret != ST_IDLE) cs_n <= 1'b0;
                end else begin
                    gcnt <= gcnt + GW'(1);
                end
                ST_WEN: if (sh_done) begin
                    pend <= 1'b0;
                    cs_n <= 1'b1;
                    st   <= ST_GAP;
                    ret  <= ST_CMD;
                end
                ST_CMD: if (sh_done) begin
                    pend <= 1'b0;
                    if (cur.op == OP_WRSR) begin
                        st <= ST_DATA;
                    end else if (cur.op == OP_PAGE || cur.op == OP_SECT || cur.op == OP_BLOCK) begin
                        st <= ST_ADDR;
                    end else begin
                        cs_n <= 1'b1;
                        st   <= ST_GAP;
                        ret  <= ST_POLL;
                    end
                end
                ST_ADDR: if (sh_done) begin
                    pend <= 1'b0;
                    if (bcnt == 8'd2) begin
                        bcnt <= '0;
                        if (cur.op == OP_PAGE) begin
                            st <= ST_DATA;
                        end else begin
                            cs_n <= 1'b1;
                            st   <= ST_GAP;
                            ret  <= ST_POLL;
                        end
                    end else begin
                        bcnt <= bcnt + 8'd1;
                    end
                end
                ST_DATA: if (sh_done) begin
                    pend <= 1'b0;
                    if (bcnt == last_data) begin
                        bcnt <= '0;
                        cs_n <= 1'b1;
                        st   <= ST_GAP;
                        ret  <= ST_POLL;
                    end else begin
                        bcnt <= bcnt + 8'd1;
                    end
                end
                ST_POLL: if (sh_done) begin
                    pend <= 1'b0;
                    if (bcnt == 8'd0) begin
                        bcnt <= 8'd1;
                    end else begin
                        bcnt <= 8'd2;
                        if ((bcnt == 8'd1) && !sh_rx[0] && !sh_rx[1]) begin
                            err_prot <= 1'b1;
                            done     <= 1'b1;
                            cs_n     <= 1'b1;
                            st       <= ST_GAP;
                            ret      <= ST_IDLE;
                            bcnt     <= '0;
                        end else if (!sh_rx[0]) begin
                            done <= 1'b1;
                            cs_n <= 1'b1;
                            st   <= ST_GAP;
                            ret  <= ST_IDLE;
                            bcnt <= '0;
                        end else if (pcnt == TW'(TMO_POLLS - 1)) begin
                            err_timeout <= 1'b1;
                            done        <= 1'b1;
                            cs_n        <= 1'b1;
                            st          <= ST_GAP;
                            ret         <= ST_IDLE;
                            bcnt        <= '0;
                        end else begin
                            pcnt <= pcnt + TW'(1);
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
    import flash_seq_pkg::*;
#(
    parameter int SCLK_DIV  = 2,
    parameter int CS_GAP    = 3,
    parameter int TMO_POLLS = 1000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [2:0]  req_op,
    input  logic [23:0] req_addr,
    input  logic [7:0]  req_len_m1,
    input  logic        wr_valid,
    input  logic [7:0]  wr_data,
    output logic        wr_ready,
    output logic        done,
    output logic        err_prot,
    output logic        err_timeout,
    output logic        sclk,
    output logic        cs_n,
    output logic        mosi,
    input  logic        miso
);
    seq_req_t   req;
    logic       sh_start;
    logic [7:0] sh_tx;
    logic       sh_done;
    logic [7:0] sh_rx;

    assign req = '{op: req_op, addr: req_addr, len_m1: req_len_m1};

    flash_seq_ctrl #(
        .CS_GAP    (CS_GAP),
        .TMO_POLLS (TMO_POLLS)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req         (req),
        .req_ready   (req_ready),
        .wr_valid    (wr_valid),
        .wr_data     (wr_data),
        .wr_ready    (wr_ready),
        .done        (done),
        .err_prot    (err_prot),
        .err_timeout (err_timeout),
        .cs_n        (cs_n),
        .sh_start    (sh_start),
        .sh_tx       (sh_tx),
        .sh_done     (sh_done),
        .sh_rx       (sh_rx)
    );

    flash_spi_shift #(
        .SCLK_DIV (SCLK_DIV)
    ) u_shift (
        .clk   (clk),
        .rst   (rst),
        .start (sh_start),
        .tx    (sh_tx),
        .miso  (miso),
        .sclk  (sclk),
        .mosi  (mosi),
        .done  (sh_done),
        .rx    (sh_rx)
    );
endmodule

// File: rtl/flash_prog_seq_chk.sv
module flash_prog_seq_chk #(
    parameter int SCLK_DIV = 2,
    parameter int CS_GAP   = 3
) (
    input logic clk,
    input logic rst,
    input logic sclk,
    input logic cs_n,
    input logic done,
    input logic err_prot,
    input logic err_timeout,
    input logic wr_ready,
    input logic req_ready
);
    logic        sclk_q;
    logic [2:0]  edge_cnt;
    logic [15:0] cs_hi;
    logic [15:0] sclk_hi;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q   <= 1'b0;
            edge_cnt <= '0;
            cs_hi    <= 16'(CS_GAP);
            sclk_hi  <= '0;
        end else begin
            sclk_q <= sclk;
            if (cs_n)                 edge_cnt <= '0;
            else if (sclk && !sclk_q) edge_cnt <= edge_cnt + 3'd1;
            if (!cs_n)                   cs_hi <= '0;
            else if (cs_hi < 16'(CS_GAP)) cs_hi <= cs_hi + 16'd1;
            if (!sclk)                  sclk_hi <= '0;
            else if (sclk_hi != 16'hFFFF) sclk_hi <= sclk_hi + 16'd1;
        end
    end

    a_r5_byte_frame: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |-> (edge_cnt == 3'd0));
    a_r5_sclk_idle: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk);
    a_r6_cs_gap: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> (cs_hi >= 16'(CS_GAP)));
    a_r7_high_phase: assert property (@(posedge clk) disable iff (rst)
        $fell(sclk) |-> (sclk_hi == 16'(SCLK_DIV)));
    a_r8_ready_in_frame: assert property (@(posedge clk) disable iff (rst)
        wr_ready |-> (!cs_n && !sclk));
    a_r1_idle_released: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> cs_n);
    a_r12_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r10_flag_with_done: assert property (@(posedge clk) disable iff (rst)
        (err_prot || err_timeout) |-> done);
    a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        done |-> !(err_prot && err_timeout));
endmodule

bind flash_prog_seq flash_prog_seq_chk #(
    .SCLK_DIV (SCLK_DIV),
    .CS_GAP   (CS_GAP)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .sclk        (sclk),
    .cs_n        (cs_n),
    .done        (done),
    .err_prot    (err_prot),
    .err_timeout (err_timeout),
    .wr_ready    (wr_ready),
    .req_ready   (req_ready)
);

// File: tb/test_flash_prog_seq.sv
module test_flash_prog_seq;
    localparam int DIV = 2;
    localparam int GAP = 3;
    localparam int TMO = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_op = '0;
    logic [23:0] req_addr = '0;
    logic [7:0]  req_len_m1 = '0;
    logic        wr_valid = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        wr_ready;
    logic        done, err_prot, err_timeout;
    logic        sclk, cs_n, mosi;
    logic        miso = 1'b0;

    always #4 clk = ~clk;

    flash_prog_seq #(.SCLK_DIV(DIV), .CS_GAP(GAP), .TMO_POLLS(TMO)) i_flash_prog_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_len_m1(req_len_m1),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
        .done(done), .err_prot(err_prot), .err_timeout(err_timeout),
        .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // flash model state
    bit         mon_on = 1'b0;
    logic       m_wel = 0, m_wip = 0, m_prot = 0;
    int         m_rem = 0, m_busy_len = 0;
    int         nbits = 0;
    logic [7:0] cur_in = 0, st_sh = 0;
    logic [7:0] fr [0:3][0:263];
    int         fr_len [0:3];
    int         nfr = 0, frame_err = 0, sb_cnt = 0;
    int         cyc = 0, cyc_rise = 0, min_gap = 1000000;
    int         hi_bad = 0;
    int         t_rise = 0;
    int         n_done = 0;
    logic       d_prot = 0, d_tmo = 0;

    always @(posedge clk) cyc++;

    always @(negedge cs_n) if (mon_on) begin
        nbits = 0;
        if (nfr > 0 && (cyc - cyc_rise) < min_gap) min_gap = cyc - cyc_rise;
    end

    always @(posedge sclk) if (mon_on && !cs_n) begin
        t_rise = int'($time);
        cur_in = {cur_in[6:0], mosi};
        nbits++;
        if (nbits % 8 == 0 && nfr < 4) begin
            if (nbits / 8 <= 264) fr[nfr][nbits/8-1] = cur_in;
            if (nbits >= 16 && fr[nfr][0] == 8'h05) begin
                sb_cnt++;
                if (m_wip) begin
                    m_rem--;
                    if (m_rem == 0) begin m_wip = 0; m_wel = 0; end
                end
            end
        end
    end

    always @(negedge sclk) if (mon_on) begin
        if (int'($time) - t_rise != DIV * 8) hi_bad++;
        if (!cs_n && nbits >= 8 && nfr < 4 && fr[nfr][0] == 8'h05) begin
            if (nbits % 8 == 0) st_sh = {6'b0, m_wel, m_wip};
            miso = st_sh[7 - (nbits % 8)];
        end
    end

    always @(posedge cs_n) if (mon_on) begin
        cyc_rise = cyc;
        if (nbits % 8 != 0) frame_err++;
        if (nfr < 4) begin
            fr_len[nfr] = nbits / 8;
            if (fr_len[nfr] == 1 && fr[nfr][0] == 8'h06) m_wel = 1;
            else if (fr_len[nfr] >= 1 && (fr[nfr][0] == 8'h02 || fr[nfr][0] == 8'h20 ||
                     fr[nfr][0] == 8'hD8 || fr[nfr][0] == 8'hC7 || fr[nfr][0] == 8'h01)) begin
                if (m_wel) begin
                    if (m_prot) m_wel = 0;
                    else begin m_wip = 1; m_rem = m_busy_len; end
                end
            end
        end
        nfr++;
    end

    always @(negedge clk) if (mon_on && done) begin
        n_done++;
        d_prot = err_prot;
        d_tmo = err_timeout;
    end

    function automatic int pat(input int i);
        return (i * 37 + 11) & 255;
    endfunction

    function automatic int exp_b(input int op, input logic [23:0] a, input int j);
        int code;
        case (op)
            0: code = 8'h02;
            1: code = 8'h20;
            2: code = 8'hD8;
            3: code = 8'hC7;
            default: code = 8'h01;
        endcase
        if (j == 0) return code;
        if (op == 4) return pat(0);
        if (j == 1) return int'(a[23:16]);
        if (j == 2) return int'(a[15:8]);
        if (j == 3) return int'(a[7:0]);
        return pat(j - 4);
    endfunction

    task automatic run_op(input int op, input logic [23:0] a, input int len_m1,
                          input bit prot, input int busy, input bit tmo, input int stall_at);
        int ndata, elen1, elen2, mism;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        m_wel = 0; m_wip = 0; m_prot = prot; m_busy_len = busy;
        nfr = 0; frame_err = 0; sb_cnt = 0; min_gap = 1000000; n_done = 0;
        req_op = 3'(op); req_addr = a; req_len_m1 = 8'(len_m1); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        ndata = (op == 0) ? len_m1 + 1 : (op == 4) ? 1 : 0;
        for (int i = 0; i < ndata; i++) begin
            wr_data = 8'(pat(i));
            wr_valid = 1'b1;
            #1;
            while (!wr_ready) begin @(negedge clk); #1; end
            @(negedge clk);
            if (i == stall_at) begin
                wr_valid = 1'b0;
                repeat (60) @(negedge clk);
                check(nbits == 8 * (4 + i + 1), "R8 sclk held at byte boundary while stalled",
                      nbits, 8 * (4 + i + 1));
            end
        end
        wr_valid = 1'b0;
        while (n_done == 0) @(negedge clk);
        while (!req_ready) @(negedge clk);
        elen1 = (op == 0) ? 4 + ndata : (op == 3) ? 1 : (op == 4) ? 2 : 4;
        elen2 = prot ? 2 : tmo ? 1 + TMO : busy + 2;
        check(frame_err == 0, "R5 frames end on byte boundary", frame_err, 0);
        check(nfr == 3, "R9 three frames per operation", nfr, 3);
        check(fr_len[0] == 1 && fr[0][0] == 8'h06, "R2 write-enable frame", int'(fr[0][0]), 6);
        check(fr_len[1] == elen1, "R3 command frame length", fr_len[1], elen1);
        mism = 0;
        for (int j = 0; j < elen1 && j < fr_len[1]; j++)
            if (int'(fr[1][j]) != exp_b(op, a, j)) mism++;
        check(mism == 0, "R4 command bytes MSB first in order", mism, 0);
        check(fr[2][0] == 8'h05 && fr_len[2] == elen2, "R9 status poll frame length",
              fr_len[2], elen2);
        check(d_prot == prot, "R10 protection error flag", int'(d_prot), int'(prot));
        check(d_tmo == tmo, "R11 timeout error flag", int'(d_tmo), int'(tmo));
        check(n_done == 1, "R12 single done pulse", n_done, 1);
        check(min_gap >= GAP, "R6 chip select high gap", min_gap, GAP);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        mon_on = 1'b1;
        check(cs_n == 1'b1, "R1 reset cs_n high", int'(cs_n), 1);
        check(sclk == 1'b0, "R1 reset sclk low", int'(sclk), 0);
        check(done == 1'b0, "R1 reset done low", int'(done), 0);
        check(req_ready == 1'b1, "R1 reset req_ready high", int'(req_ready), 1);

        for (int op = 0; op < 5; op++)
            for (int b = 1; b <= 3; b++)
                run_op(op, 24'h123456 ^ 24'(op << 20) ^ 24'(b * 24'h010203),
                       (op == 0) ? ((b == 1) ? 0 : (b == 2) ? 4 : 255) : 0,
                       1'b0, b, 1'b0, -1);
        for (int op = 0; op < 5; op++)
            run_op(op, 24'hA5C3F0, 2, 1'b1, 1, 1'b0, -1);
        run_op(1, 24'h0F1E2D, 0, 1'b0, 1000, 1'b1, -1);
        run_op(0, 24'hFFFFF8, 7, 1'b0, 2, 1'b0, 2);
        check(hi_bad == 0, "R7 sclk high phase length", hi_bad, 0);
        finish_run();
    end
endmodule